// File: doc/BRIEF.md
# Reloading 24-bit Tick Timer

This block is a periodic tick source for a processor subsystem. A down-counter steps once for each tick-enable pulse while it is switched on. When it steps from 1 it refills from a programmed reload value, sets a sticky count flag and, if interrupts are allowed, sends a one-cycle pend request to the interrupt controller. The period is therefore the reload value in ticks. A counter that holds zero is frozen: ticks do nothing until the timer is started again.

Software reaches the block through a simple 32-bit word register port with four registers: control/status, reload, current value and a read-only calibration word. Switching the enable bit from 0 to 1 loads the counter from the reload register. Any write to the current value register stops the count at zero.

Top module: `tick_timer`

## Requirements
- R1: After reset, control/status reads 0x0000_0004 (only the clock-source bit set), reload reads 0, current value reads 0 and `irq_pend` is low.
- R2: While enable (control bit 0) is 1, a tick with a current value greater than 1 lowers the current value by one. Without enable or without a tick, the current value holds.
- R3: While enabled, a tick with current value 1 loads the current value from reload and sets the count flag (control bit 16).
- R4: On that terminal tick, if tick-interrupt-enable (control bit 1) is 1, `irq_pend` is high for the single cycle after the clock edge. If the bit is 0, no pulse is raised.
- R5: A current value of 0 is unchanged by ticks.
- R6: A read of control/status returns the count flag and clears it. If a terminal tick occurs in the same cycle as the read, the flag stays set.
- R7: Any write to the current value register, whatever the data, sets the counter and the count flag to 0.
- R8: The calibration register (word address 3) reads CAL_VALUE (default 0xC000_0000). Writes to it are ignored.
- R9: Reload keeps only bits [CNT_W-1:0]. Upper bits of reload and of the current value read as 0.
- R10: A control write that takes enable from 0 to 1 loads the current value from reload.
- R11: Word addresses are 0 control/status, 1 reload, 2 current value, 3 calibration. Control bit 2 is the clock-source status, and unlisted control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-step pulse, one per tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq_pend | output | 1 | One-cycle pend request to the interrupt controller |

## Verification
The bench builds the block with its default 24-bit counter and the default calibration word. Small reload values bring the terminal tick, the interrupt pulse and the flag race within a few cycles. A reload of all ones reaches the top of the counter range and the masking of the upper bits. Read results go through a queue of expected words and are compared as each read completes. Interrupt and freeze behaviour are checked at the pins in the cycle after each tick.

// File: rtl/tick_timer_pkg.sv
// Shared definitions for the tick timer: register word addresses and
// control/status bit positions. Assumes a 32-bit register data path.
package tick_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_CALIB   = 2'd3
    } reg_sel_e;

    localparam int BIT_ENABLE  = 0;
    localparam int BIT_TICKINT = 1;
    localparam int BIT_CLKSRC  = 2;
    localparam int BIT_FLAG    = 16;
endpackage

// File: rtl/tick_timer_regs.sv
// Register file of the tick timer. It holds the control bits and the
// reload value, decodes writes into strobes for the counter, and muxes
// read data. Assumes the counter state (value, flag) comes from
// tick_timer_count and that reads are free of wait states.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int                 CNT_W      = 24,
    parameter logic [DATA_W-1:0]  CAL_VALUE  = 32'hC000_0000,
    parameter logic               CLKSRC_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic              cnt_flag,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              run_en,
    output logic              tick_irq_en,
    output logic [CNT_W-1:0]  reload_val,
    output logic              start_load,
    output logic              clear_cnt,
    output logic              flag_rd
);
    logic clk_src;
    logic wr_ctrl;

    // Decode write and read strobes for the counter.
    always_comb begin
        wr_ctrl    = reg_wr && (reg_addr == SEL_CTRL);
        start_load = wr_ctrl && reg_wdata[BIT_ENABLE] && !run_en;
        clear_cnt  = reg_wr && (reg_addr == SEL_CURRENT);
        flag_rd    = reg_rd && (reg_addr == SEL_CTRL);
    end

    // Control bits: enable, interrupt enable, clock-source status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en      <= 1'b0;
            tick_irq_en <= 1'b0;
            clk_src     <= CLKSRC_RST;
        end else if (wr_ctrl) begin
            run_en      <= reg_wdata[BIT_ENABLE];
            tick_irq_en <= reg_wdata[BIT_TICKINT];
            clk_src     <= reg_wdata[BIT_CLKSRC];
        end
    end

    // Reload register keeps only the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_val <= '0;
        else if (reg_wr && (reg_addr == SEL_RELOAD))
            reload_val <= reg_wdata[CNT_W-1:0];
    end

    // Read mux; unused bits read zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            SEL_CTRL: begin
                reg_rdata[BIT_ENABLE]  = run_en;
                reg_rdata[BIT_TICKINT] = tick_irq_en;
                reg_rdata[BIT_CLKSRC]  = clk_src;
                reg_rdata[BIT_FLAG]    = cnt_flag;
            end
            SEL_RELOAD:  reg_rdata = DATA_W'(reload_val);
            SEL_CURRENT: reg_rdata = DATA_W'(cnt_value);
            SEL_CALIB:   reg_rdata = CAL_VALUE;
            default:     reg_rdata = '0;
        endcase
    end

    // R10: a start strobe leaves the timer enabled.
    assert_start_enables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> run_en);
endmodule

// File: rtl/tick_timer_count.sv
// Down-counter core of the tick timer. It steps on enabled ticks, reloads
// on the step from 1, freezes at 0, and keeps the sticky count flag and the
// registered pend pulse. Assumes strobes from tick_timer_regs are single
// cycle and that clear has priority over start, and start over ticks.
module tick_timer_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run_en,
    input  logic             tick_irq_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             start_load,
    input  logic             clear_cnt,
    input  logic             flag_rd,
    output logic [CNT_W-1:0] cnt_value,
    output logic             cnt_flag,
    output logic             irq_pend
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic live_tick;
    logic step_down;
    logic terminal;

    // Classify this cycle's tick.
    always_comb begin
        live_tick = tick_en && run_en && !clear_cnt && !start_load;
        step_down = live_tick && (cnt_value > ONE);
        terminal  = live_tick && (cnt_value == ONE);
    end

    // Counter value update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_value <= '0;
        else if (clear_cnt)
            cnt_value <= '0;
        else if (start_load)
            cnt_value <= reload_val;
        else if (step_down)
            cnt_value <= cnt_value - ONE;
        else if (terminal)
            cnt_value <= reload_val;
    end

    // Sticky flag: set wins over the read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_flag <= 1'b0;
        else if (clear_cnt)
            cnt_flag <= 1'b0;
        else if (terminal)
            cnt_flag <= 1'b1;
        else if (flag_rd)
            cnt_flag <= 1'b0;
    end

    // One-cycle pend pulse after a terminal tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_pend <= 1'b0;
        else
            irq_pend <= terminal && tick_irq_en;
    end

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_down |=> (cnt_value == $past(cnt_value) - ONE));
    assert_reload_at_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        terminal |=> (cnt_value == $past(reload_val)) && cnt_flag);
    assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend |-> cnt_flag);
    assert_zero_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value == '0 && !start_load) |=> (cnt_value == '0));
    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_cnt |=> (cnt_value == '0) && !cnt_flag);
endmodule

// File: rtl/tick_timer.sv
// Top of the reloading tick timer: joins the register file and the
// counter core. Assumes one register access per cycle and a tick_en
// that is a clean synchronous pulse.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int                 CNT_W     = 24,
    parameter logic [DATA_W-1:0]  CAL_VALUE = 32'hC000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pend
);
    logic [CNT_W-1:0] cnt_value;
    logic             cnt_flag;
    logic             run_en;
    logic             tick_irq_en;
    logic [CNT_W-1:0] reload_val;
    logic             start_load;
    logic             clear_cnt;
    logic             flag_rd;

    tick_timer_regs #(
        .CNT_W      (CNT_W),
        .CAL_VALUE  (CAL_VALUE),
        .CLKSRC_RST (1'b1)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .cnt_value   (cnt_value),
        .cnt_flag    (cnt_flag),
        .reg_rdata   (reg_rdata),
        .run_en      (run_en),
        .tick_irq_en (tick_irq_en),
        .reload_val  (reload_val),
        .start_load  (start_load),
        .clear_cnt   (clear_cnt),
        .flag_rd     (flag_rd)
    );

    tick_timer_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .run_en      (run_en),
        .tick_irq_en (tick_irq_en),
        .reload_val  (reload_val),
        .start_load  (start_load),
        .clear_cnt   (clear_cnt),
        .flag_rd     (flag_rd),
        .cnt_value   (cnt_value),
        .cnt_flag    (cnt_flag),
        .irq_pend    (irq_pend)
    );
endmodule

// File: tb/tb_tick_timer.sv
// Scoreboard bench: read tasks queue the expected word, a monitor
// compares it with reg_rdata while the read strobe is held.
module tb_tick_timer;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_RLD = 2'd1, A_CUR = 2'd2, A_CAL = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_pend;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    tick_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_pend(irq_pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare each read against the queued expectation.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (reg_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                fails++;
                $display("FAIL %s: read got %h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // One tick; returns at the negedge just after the tick's clock edge.
    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_pend !== e) begin
            fails++;
            $display("FAIL %s: irq_pend got %b expected %b", t, irq_pend, e);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R11 reset values and map
        chk_irq(1'b0, "R1 irq at reset");
        rd(A_CTRL, 32'h0000_0004, "R1 ctrl reset");
        rd(A_RLD,  32'h0,         "R1 reload reset");
        rd(A_CUR,  32'h0,         "R1 current reset");
        rd(A_CAL,  32'hC000_0000, "R8 calib reset");
        // R10 start loads reload
        wr(A_RLD, 32'd3);
        wr(A_CTRL, 32'h7);
        rd(A_CUR, 32'd3, "R10 start load");
        // R2 decrement
        tick();
        rd(A_CUR, 32'd2, "R2 step 3->2");
        tick();
        rd(A_CUR, 32'd1, "R2 step 2->1");
        // R3 / R4 terminal tick with interrupt
        tick();
        chk_irq(1'b1, "R4 pulse after terminal");
        @(negedge clk);
        chk_irq(1'b0, "R4 pulse one cycle");
        rd(A_CUR, 32'd3, "R3 reload");
        // R6 flag read and clear; R11 field layout
        rd(A_CTRL, 32'h0001_0007, "R6 flag set");
        rd(A_CTRL, 32'h0000_0007, "R6 flag cleared");
        // R4 no pulse without tick-interrupt-enable
        wr(A_CTRL, 32'h5);
        tick(); tick(); tick();
        chk_irq(1'b0, "R4 no pulse when disabled");
        rd(A_CTRL, 32'h0001_0005, "R3 flag without irq");
        // R7 write to current clears counter and flag
        wr(A_CUR, 32'h0000_0ABC);
        rd(A_CUR, 32'h0, "R7 counter cleared");
        rd(A_CTRL, 32'h0000_0005, "R7 flag cleared");
        // R5 zero is frozen
        tick(); tick();
        chk_irq(1'b0, "R5 no pulse at zero");
        rd(A_CUR, 32'h0, "R5 frozen at zero");
        // R2 hold while disabled
        wr(A_CTRL, 32'h4);
        wr(A_CTRL, 32'h5);
        wr(A_CTRL, 32'h4);
        tick();
        rd(A_CUR, 32'd3, "R2 hold when disabled");
        // R8 calibration writes ignored
        wr(A_CAL, 32'h0000_1234);
        rd(A_CAL, 32'hC000_0000, "R8 write ignored");
        // R9 reload width
        wr(A_RLD, 32'hFFFF_FFFF);
        rd(A_RLD, 32'h00FF_FFFF, "R9 reload masked");
        wr(A_CTRL, 32'h5);
        tick();
        rd(A_CUR, 32'h00FF_FFFE, "R9 top of range step");
        // R6 terminal tick in the same cycle as the control read
        wr(A_RLD, 32'd2);
        wr(A_CTRL, 32'h4);
        wr(A_CTRL, 32'h5);
        tick();
        @(negedge clk);
        tick_en = 1'b1; reg_rd = 1'b1; reg_addr = A_CTRL;
        exp_q.push_back(32'h0000_0005); tag_q.push_back("R6 read before race");
        @(negedge clk);
        tick_en = 1'b0; reg_rd = 1'b0;
        rd(A_CTRL, 32'h0001_0005, "R6 set wins over read clear");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule